// File: doc/BRIEF.md
# Narrow Boot ROM Instruction Fetcher

This block connects a processor's 64-bit instruction-fetch port to two memory paths. One is an 8-bit boot ROM and the other is a full-width instruction memory. After reset the block is in narrow mode. In narrow mode it answers each fetch with eight byte reads, issued one after another at ascending addresses. It then assembles the bytes into two 32-bit instruction words. The boot image holds every 32-bit instruction with its bytes reversed: the byte at the lowest address of a word is the most significant byte of the instruction. The block undoes that reversal, so the core receives the same words it would get from a little-endian image.

A mode-select input moves the block to wide mode. The switch is only accepted while no fetch is in flight. In wide mode each fetch becomes one full-width read, and the data passes through unchanged. Requests that are not aligned to a 64-bit unit are rejected at once with an error flag, and no memory read is made for them. Each ROM read has a fixed latency, set by a parameter, and the byte address is held stable until the data has been captured.

Top module: `bootfetch_top`

## Requirements
- R1: After reset the block is in narrow mode. `wide_active` is 0, `req_ready` is 1, no read strobe is asserted, and the first aligned fetch uses byte reads only (no `wide_rd`).
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the response. `rsp_done` is a single-cycle pulse that closes each accepted request.
- R3: A narrow fetch at base address A makes exactly eight `rom_rd` strobes, one at a time, at addresses A, A+1, …, A+7. After each strobe, `rom_addr` is held for the next RD_LAT cycles.
- R4: In narrow mode, the byte read from offset k of the fetch (k = 0..7) lands in `rsp_insn` bits [8*L+7 : 8*L], where L = 4*(k/4) + 3 - (k%4). Offset 0 therefore fills bits 31:24 of the first instruction (bits 31:0), and offset 4 fills bits 63:56 of the second instruction (bits 63:32).
- R5: In wide mode a fetch makes exactly one `wide_rd` at the base address and no `rom_rd`. `rsp_insn` equals `wide_data` unchanged, so the byte at the lowest address is in bits 7:0. For the same code, this gives the same instruction words as narrow mode does on the byte-reversed image.
- R6: A request with any of `req_addr[2:0]` set is answered in the next cycle with `rsp_done` = 1, `rsp_err` = 1 and `rsp_insn` = 0, and no read strobe is issued for it. `rsp_err` is 1 only together with `rsp_done`.
- R7: `go_wide` is sampled only while the block is idle (`req_ready` = 1). Once sampled high, `wide_active` stays 1 until reset. A fetch accepted in that same cycle, or already in flight, completes in narrow mode. A `go_wide` pulse that lies wholly inside a fetch has no effect.
- R8: Counting the accepting clock edge as 1, `rsp_done` becomes visible after 8*(RD_LAT+1)+1 edges for a narrow fetch, after RD_LAT+2 edges for a wide fetch, and after 1 edge for a misaligned request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_wide | input | 1 | Request to move to wide mode (sampled while idle) |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Byte address of the 64-bit fetch |
| rsp_done | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an alignment error |
| rsp_insn | output | 64 | Two instruction words, first word in bits 31:0 |
| wide_active | output | 1 | Wide mode in force for the next accepted fetch |
| rom_rd | output | 1 | Byte read strobe to the boot ROM |
| rom_addr | output | ADDR_W | Byte address to the boot ROM |
| rom_byte | input | 8 | ROM read data, valid RD_LAT cycles after the strobe |
| wide_rd | output | 1 | Full-width read strobe |
| wide_addr | output | ADDR_W | Byte address of the full-width read |
| wide_data | input | 64 | Full-width read data, valid RD_LAT cycles after the strobe |

## Verification
A wrong byte index or a wrong lane mapping shows up in `rsp_insn` on the very response that covers that fetch. Swapped or shifted bytes in either word are caught at once against instruction words computed from the opcode formula. A sequencer or latency counter that is off by one either samples ROM data outside its valid window, which the ROM model fills with a fixed filler byte, or moves `rsp_done` away from its expected edge count. In either case the fault appears within a single fetch. A mode flag that is updated at the wrong moment changes the read strobes and the response timing of the next fetch, so the bench counts strobes and edges around every mode-switch scenario.

// File: rtl/bootfetch_pkg.sv
package bootfetch_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NISSUE,
      ST_NWAIT,
      ST_WISSUE,
      ST_WWAIT,
      ST_RESP
   } fetch_state_t;

   // Result lane for the byte read from fetch offset k: the byte order is
   // reversed inside each word, and the word order is kept.
   function automatic int unsigned lane_of(input int unsigned k, input int unsigned wb);
      return (k / wb) * wb + (wb - 1 - (k % wb));
   endfunction

endpackage

// File: rtl/bootfetch_lat_timer.sv
module bootfetch_lat_timer #(
   parameter int unsigned LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expire
);
   localparam int unsigned CNT_W = $clog2(LAT + 1) + 1;
   localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   assign expire = busy_q && (cnt_q == LAT_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_W'(1);
      end else if (expire) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/bootfetch_packer.sv
module bootfetch_packer
   import bootfetch_pkg::*;
#(
   parameter int unsigned WORD_BYTES  = 4,
   parameter int unsigned FETCH_BYTES = 8,
   localparam int unsigned IDX_W      = $clog2(FETCH_BYTES),
   localparam int unsigned FETCH_W    = 8 * FETCH_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               byte_we,
   input  logic [IDX_W-1:0]   byte_idx,
   input  logic [7:0]         byte_in,
   input  logic               word_we,
   input  logic [FETCH_W-1:0] word_in,
   output logic [FETCH_W-1:0] data_out
);
   // One byte register per result lane. Each lane is written by exactly one
   // fetch offset, fixed at elaboration.
   for (genvar g = 0; g < FETCH_BYTES; g++) begin : g_lane
      localparam int unsigned SRC = lane_of(g, WORD_BYTES);
      logic [7:0] lane_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (clr) begin
            lane_q <= '0;
         end else if (word_we) begin
            lane_q <= word_in[g*8 +: 8];
         end else if (byte_we && (byte_idx == IDX_W'(SRC))) begin
            lane_q <= byte_in;
         end
      end

      assign data_out[g*8 +: 8] = lane_q;
   end
endmodule

// File: rtl/bootfetch_ctrl.sv
module bootfetch_ctrl
   import bootfetch_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_wide,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              expire,
   output logic              req_ready,
   output logic              accept,
   output logic              rom_rd,
   output logic              wide_rd,
   output logic              byte_we,
   output logic              word_we,
   output logic              done,
   output logic              err,
   output logic              wide_active,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] base
);
   localparam logic [IDX_W-1:0] LAST_IDX = '1;

   fetch_state_t      state_q;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic              err_q;
   logic              wide_q;
   logic              misaligned;

   assign misaligned = |req_addr[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         idx_q   <= '0;
         err_q   <= 1'b0;
         wide_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               wide_q <= wide_q | go_wide;
               if (req_valid) begin
                  base_q <= req_addr;
                  idx_q  <= '0;
                  err_q  <= misaligned;
                  if (misaligned)  state_q <= ST_RESP;
                  else if (wide_q) state_q <= ST_WISSUE;
                  else             state_q <= ST_NISSUE;
               end
            end
            ST_NISSUE: state_q <= ST_NWAIT;
            ST_NWAIT: begin
               if (expire) begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= ST_RESP;
                  end else begin
                     idx_q   <= idx_q + IDX_W'(1);
                     state_q <= ST_NISSUE;
                  end
               end
            end
            ST_WISSUE: state_q <= ST_WWAIT;
            ST_WWAIT: begin
               if (expire) state_q <= ST_RESP;
            end
            ST_RESP: begin
               err_q   <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready   = (state_q == ST_IDLE);
      accept      = req_ready && req_valid;
      rom_rd      = (state_q == ST_NISSUE);
      wide_rd     = (state_q == ST_WISSUE);
      byte_we     = (state_q == ST_NWAIT) && expire;
      word_we     = (state_q == ST_WWAIT) && expire;
      done        = (state_q == ST_RESP);
      err         = done && err_q;
      wide_active = wide_q;
      idx         = idx_q;
      base        = base_q;
   end
endmodule

// File: rtl/bootfetch_top.sv
module bootfetch_top
   import bootfetch_pkg::*;
#(
   parameter int unsigned ADDR_W          = 16,
   parameter int unsigned RD_LAT          = 2,
   parameter int unsigned WORD_BYTES      = 4,
   parameter int unsigned WORDS_PER_FETCH = 2,
   localparam int unsigned FETCH_BYTES    = WORD_BYTES * WORDS_PER_FETCH,
   localparam int unsigned IDX_W          = $clog2(FETCH_BYTES),
   localparam int unsigned FETCH_W        = 8 * FETCH_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_wide,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_done,
   output logic               rsp_err,
   output logic [FETCH_W-1:0] rsp_insn,
   output logic               wide_active,
   output logic               rom_rd,
   output logic [ADDR_W-1:0]  rom_addr,
   input  logic [7:0]         rom_byte,
   output logic               wide_rd,
   output logic [ADDR_W-1:0]  wide_addr,
   input  logic [FETCH_W-1:0] wide_data
);
   if (RD_LAT < 1) begin : g_bad_lat
      $error("bootfetch_top: RD_LAT must be at least 1");
   end
   if ((WORD_BYTES < 2) || ((WORD_BYTES & (WORD_BYTES - 1)) != 0)) begin : g_bad_word
      $error("bootfetch_top: WORD_BYTES must be a power of two, at least 2");
   end
   if ((WORDS_PER_FETCH < 1) || ((WORDS_PER_FETCH & (WORDS_PER_FETCH - 1)) != 0)) begin : g_bad_words
      $error("bootfetch_top: WORDS_PER_FETCH must be a power of two");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("bootfetch_top: ADDR_W too small for the fetch size");
   end

   logic              accept;
   logic              expire;
   logic              byte_we;
   logic              word_we;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] base;

   bootfetch_ctrl #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_wide     (go_wide),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .expire      (expire),
      .req_ready   (req_ready),
      .accept      (accept),
      .rom_rd      (rom_rd),
      .wide_rd     (wide_rd),
      .byte_we     (byte_we),
      .word_we     (word_we),
      .done        (rsp_done),
      .err         (rsp_err),
      .wide_active (wide_active),
      .idx         (idx),
      .base        (base)
   );

   bootfetch_lat_timer #(
      .LAT (RD_LAT)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (rom_rd | wide_rd),
      .expire (expire)
   );

   bootfetch_packer #(
      .WORD_BYTES  (WORD_BYTES),
      .FETCH_BYTES (FETCH_BYTES)
   ) u_packer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .byte_we  (byte_we),
      .byte_idx (idx),
      .byte_in  (rom_byte),
      .word_we  (word_we),
      .word_in  (wide_data),
      .data_out (rsp_insn)
   );

   assign rom_addr  = {base[ADDR_W-1:IDX_W], idx};
   assign wide_addr = base;
endmodule

// File: rtl/bootfetch_chk.sv
module bootfetch_chk #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned RD_LAT      = 2,
   parameter int unsigned FETCH_BYTES = 8,
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned FETCH_W     = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [IDX_W-1:0]   req_lsb,
   input logic               rsp_done,
   input logic               rsp_err,
   input logic [FETCH_W-1:0] rsp_insn,
   input logic               wide_active,
   input logic               rom_rd,
   input logic [ADDR_W-1:0]  rom_addr,
   input logic               wide_rd
);
   localparam logic [15:0] NARROW_CYC = 16'(FETCH_BYTES * (RD_LAT + 1) + 1);
   localparam logic [15:0] WIDE_CYC   = 16'(RD_LAT + 2);
   localparam logic [7:0]  N_READS    = 8'(FETCH_BYTES);

   logic              accept;
   logic [15:0]       cyc_q;
   logic [7:0]        rd_cnt_q;
   logic              wide_seen_q;
   logic              any_rd_q;
   logic [ADDR_W-1:0] last_addr_q;

   assign accept = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q       <= '0;
         rd_cnt_q    <= '0;
         wide_seen_q <= 1'b0;
         any_rd_q    <= 1'b0;
         last_addr_q <= '0;
      end else if (accept) begin
         cyc_q       <= 16'd1;
         rd_cnt_q    <= '0;
         wide_seen_q <= 1'b0;
         any_rd_q    <= 1'b0;
      end else begin
         if (!req_ready && !rsp_done) cyc_q <= cyc_q + 16'd1;
         if (rom_rd) begin
            rd_cnt_q    <= rd_cnt_q + 8'd1;
            any_rd_q    <= 1'b1;
            last_addr_q <= rom_addr;
         end
         if (wide_rd) wide_seen_q <= 1'b1;
      end
   end

   assert_wide_only_after_switch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wide_rd |-> wide_active);

   assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !req_ready);

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd |=> ($stable(rom_addr) && !rom_rd));

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd && any_rd_q) |-> (rom_addr == last_addr_q + ADDR_W'(1)));

   assert_eight_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_err && !wide_seen_q) |-> (rd_cnt_q == N_READS));

   assert_paths_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_rd && wide_rd));

   assert_misalign_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (|req_lsb)) |=> (rsp_done && rsp_err && (rsp_insn == '0) && !rom_rd && !wide_rd));

   assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);

   assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wide_active |=> wide_active);

   assert_mode_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wide_active) |-> $past(req_ready));

   assert_narrow_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_err && !wide_seen_q) |-> (cyc_q == NARROW_CYC));

   assert_wide_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && wide_seen_q) |-> (cyc_q == WIDE_CYC));
endmodule

bind bootfetch_top bootfetch_chk #(
   .ADDR_W      (ADDR_W),
   .RD_LAT      (RD_LAT),
   .FETCH_BYTES (FETCH_BYTES),
   .IDX_W       (IDX_W),
   .FETCH_W     (FETCH_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_lsb     (req_addr[IDX_W-1:0]),
   .rsp_done    (rsp_done),
   .rsp_err     (rsp_err),
   .rsp_insn    (rsp_insn),
   .wide_active (wide_active),
   .rom_rd      (rom_rd),
   .rom_addr    (rom_addr),
   .wide_rd     (wide_rd)
);

// File: tb/tb_bootfetch_top.sv
`timescale 1ns/1ps
module tb_bootfetch_top;
   localparam int LAT     = 3;
   localparam int AW      = 8;
   localparam int NBYTES  = 256;
   localparam int N_CYC   = 8 * (LAT + 1) + 1;
   localparam int W_CYC   = LAT + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          go_wide = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_done;
   logic          rsp_err;
   logic [63:0]   rsp_insn;
   logic          wide_active;
   logic          rom_rd;
   logic [AW-1:0] rom_addr;
   logic [7:0]    rom_byte;
   logic          wide_rd;
   logic [AW-1:0] wide_addr;
   logic [63:0]   wide_data;

   int vectors = 0;
   int fails   = 0;

   always #2 clk = ~clk;

   bootfetch_top #(
      .ADDR_W (AW),
      .RD_LAT (LAT)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_wide     (go_wide),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr    (req_addr),
      .rsp_done    (rsp_done),
      .rsp_err     (rsp_err),
      .rsp_insn    (rsp_insn),
      .wide_active (wide_active),
      .rom_rd      (rom_rd),
      .rom_addr    (rom_addr),
      .rom_byte    (rom_byte),
      .wide_rd     (wide_rd),
      .wide_addr   (wide_addr),
      .wide_data   (wide_data)
   );

   // Opcodes and the two memory images built from them.
   function automatic logic [31:0] opcode(input int i);
      return 32'hA000_0000 + 32'(i) * 32'h0103_0507;
   endfunction

   logic [7:0] narrow_img [NBYTES];
   logic [7:0] le_img     [NBYTES];

   initial begin
      for (int i = 0; i < NBYTES / 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            narrow_img[4*i + j] = opcode(i)[8*(3-j) +: 8];
            le_img[4*i + j]     = opcode(i)[8*j +: 8];
         end
      end
   end

   function automatic logic [63:0] le_group(input logic [AW-1:0] a);
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[8*k +: 8] = le_img[int'({a[AW-1:3], 3'b000}) + k];
      return v;
   endfunction

   // Read latency models: data is presented LAT edges after the strobe and is
   // a filler value at any other time.
   logic [7:0]  npipe [LAT];
   logic [63:0] wpipe [LAT];
   always @(posedge clk) begin
      for (int i = LAT - 1; i > 0; i--) begin
         npipe[i] <= npipe[i-1];
         wpipe[i] <= wpipe[i-1];
      end
      npipe[0] <= rom_rd  ? narrow_img[rom_addr] : 8'hA5;
      wpipe[0] <= wide_rd ? le_group(wide_addr) : 64'hDEAD_BEEF_0BAD_F00D;
   end
   assign rom_byte  = npipe[LAT-1];
   assign wide_data = wpipe[LAT-1];

   // Read monitor.
   int            rd_n = 0;
   int            wr_n = 0;
   int            hold_err = 0;
   int            hold_left = 0;
   logic [AW-1:0] hold_addr = '0;
   logic [AW-1:0] rd_log [16];

   always @(negedge clk) begin
      if (hold_left > 0) begin
         if (rom_addr !== hold_addr) hold_err++;
         hold_left--;
      end
      if (rom_rd) begin
         if (rd_n < 16) rd_log[rd_n] = rom_addr;
         rd_n++;
         hold_left = LAT;
         hold_addr = rom_addr;
      end
      if (wide_rd) wr_n++;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic fetch(input logic [AW-1:0] a, output logic [63:0] d, output logic e,
                        output int n, output logic busy_ready, output logic done_after);
      @(negedge clk);
      rd_n = 0;
      wr_n = 0;
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      n = 1;
      @(negedge clk);
      req_valid  = 1'b0;
      busy_ready = req_ready;
      while (!rsp_done) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      d = rsp_insn;
      e = rsp_err;
      @(negedge clk);
      done_after = rsp_done;
   endtask

   function automatic bit seq_ok(input logic [AW-1:0] a);
      for (int i = 0; i < 8; i++) if (rd_log[i] !== a + AW'(i)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic narrow_fetch(input logic [AW-1:0] a);
      logic [63:0] d; logic e; int n; logic br; logic da;
      logic [63:0] exp;
      exp = {opcode(int'(a) / 4 + 1), opcode(int'(a) / 4)};
      fetch(a, d, e, n, br, da);
      chk(d === exp, "R4 narrow packing", d, exp);
      chk(e === 1'b0, "R4 no error", 64'(e), 64'd0);
      chk(n == N_CYC, "R8 narrow latency", 64'(n), 64'(N_CYC));
      chk(rd_n == 8 && wr_n == 0, "R3 byte read count", 64'(rd_n), 64'd8);
      chk(seq_ok(a), "R3 ascending byte addresses", 64'(rd_log[0]), 64'(a));
      chk(br === 1'b0 && da === 1'b0, "R2 busy and single pulse", {62'd0, br, da}, 64'd0);
   endtask

   task automatic wide_fetch(input logic [AW-1:0] a);
      logic [63:0] d; logic e; int n; logic br; logic da;
      logic [63:0] exp;
      exp = {opcode(int'(a) / 4 + 1), opcode(int'(a) / 4)};
      fetch(a, d, e, n, br, da);
      chk(d === exp, "R5 wide matches narrow words", d, exp);
      chk(n == W_CYC, "R8 wide latency", 64'(n), 64'(W_CYC));
      chk(wr_n == 1 && rd_n == 0, "R5 single wide read", 64'(wr_n), 64'd1);
      chk(br === 1'b0 && da === 1'b0, "R2 busy and single pulse", {62'd0, br, da}, 64'd0);
   endtask

   task automatic misaligned_fetch(input logic [AW-1:0] a);
      logic [63:0] d; logic e; int n; logic br; logic da;
      fetch(a, d, e, n, br, da);
      chk(e === 1'b1, "R6 error flag", 64'(e), 64'd1);
      chk(d === 64'd0, "R6 zero data", d, 64'd0);
      chk(n == 1, "R8 misaligned latency", 64'(n), 64'd1);
      chk(rd_n == 0 && wr_n == 0, "R6 no reads", 64'(rd_n + wr_n), 64'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
      chk(wide_active === 1'b0, "R1 narrow after reset", 64'(wide_active), 64'd0);
      chk(!rom_rd && !wide_rd && !rsp_done, "R1 quiet after reset",
          {61'd0, rom_rd, wide_rd, rsp_done}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : main
      do_reset();

      // R4 R3 R8: every aligned group of the image in narrow mode.
      for (int a = 0; a < NBYTES; a += 8) narrow_fetch(AW'(a));

      // R6: all misaligned offsets.
      for (int off = 1; off < 8; off++) misaligned_fetch(AW'(16 + off));

      // R7: a go_wide pulse inside a fetch has no effect.
      fork
         narrow_fetch(AW'(40));
         begin
            repeat (6) @(negedge clk);
            go_wide = 1'b1;
            @(negedge clk);
            go_wide = 1'b0;
         end
      join
      @(negedge clk);
      chk(wide_active === 1'b0, "R7 pulse during fetch ignored", 64'(wide_active), 64'd0);
      narrow_fetch(AW'(48));

      // R7: switch in the accepting cycle; that fetch stays narrow.
      fork
         narrow_fetch(AW'(64));
         begin
            @(negedge clk);
            go_wide = 1'b1;
            @(posedge clk);
            @(negedge clk);
            go_wide = 1'b0;
         end
      join
      @(negedge clk);
      chk(wide_active === 1'b1, "R7 switch taken while idle", 64'(wide_active), 64'd1);

      // R5 R8: wide sweep returns the same words.
      for (int a = 0; a < NBYTES; a += 8) wide_fetch(AW'(a));
      misaligned_fetch(AW'(3));
      chk(wide_active === 1'b1, "R7 wide mode sticky", 64'(wide_active), 64'd1);

      // R1: reset returns to narrow mode.
      do_reset();
      narrow_fetch(AW'(200));

      chk(hold_err == 0, "R3 address held during latency", 64'(hold_err), 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule